// File: doc/BRIEF.md
# Polar Node Frozen-Bit Check Unit

This unit decides whether an intermediate node of a polar successive-cancellation decoder can be resolved by hard decision alone. The node's leaves are a mix of frozen and information positions. On a start strobe the unit takes the node's signed LLR vector and a per-leaf frozen mask. It forms the hard-decision vector, re-encodes that vector through the polar transform of the node's length, and examines every frozen leaf of the result.

The node passes only if every frozen leaf of the re-encoded vector is zero. In that case the scheduler can take the hard-decision vector as the node's bit estimate and skip the subtree under it. If the node fails, the scheduler goes on with the normal traversal. Both results are registered and appear one cycle after the start strobe, with a single-cycle done pulse.

Top module: `polar_fc_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first start, est_out, pass and done are all 0.
- R2: LLR i occupies llr_in[i*LLR_W +: LLR_W] in two's complement. Hard bit i is 0 when that LLR is greater than or equal to zero and 1 when it is negative. An LLR of zero gives 0 and the most negative value gives 1.
- R3: Leaf estimate j is the XOR of the hard bits h[i] over every index i that contains all the set bits of j. This is the product with the Kronecker power of the kernel [1 0; 1 1] in natural leaf order. As a result, leaf 0 is the parity of all hard bits and leaf LEN-1 equals h[LEN-1].
- R4: Only leaves whose frz_mask bit is 1 are examined. Mask bit i belongs to leaf i, and bit 0 is the leftmost leaf. A 1 leaf estimate under a mask bit of 0 never causes a failure.
- R5: pass is 1 after a check exactly when no examined leaf estimate is 1. Otherwise pass is 0.
- R6: done is 1 in the cycle after each cycle in which start is 1, and 0 in all other cycles. est_out and pass update at the same clock edge that raises done.
- R7: est_out holds the hard-decision vector of the most recent check, and it is given out on pass and on fail alike. Without start, est_out and pass keep their values whatever llr_in and frz_mask do.
- R8: Starts on consecutive cycles each produce their own result. A failing check clears a pass left by the previous check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a check on the current inputs |
| llr_in | input | LEN*LLR_W | Node LLRs, leaf i in slice i |
| frz_mask | input | LEN | 1 marks a frozen leaf |
| est_out | output | LEN | Hard-decision vector of the last check |
| pass | output | 1 | Last check found no nonzero frozen leaf |
| done | output | 1 | One-cycle pulse, result valid |

## Verification
The bench tries several input sets, and each one separates a different kind of fault:
- All-positive LLRs give a zero transform, so any fault in the sign rule shows up as a failure.
- All-negative LLRs leave a single 1 at the last leaf. Masks that include or exclude that leaf reveal a transform or mask-alignment fault.
- A single negative LLR at leaf 0 leaves a single 1 at leaf 0, which separates natural from reversed leaf order.
- LLRs of exactly zero and of the most negative value probe the sign boundary.

Held inputs without a start check that results are not disturbed. Back-to-back starts whose outcomes differ check that each check clears the previous result. Random vectors are compared every cycle against a subset-sum model of the transform.

// File: rtl/polar_fc_pkg.sv
package polar_fc_pkg;

  // True when idx is the upper (lower-index) wing of a butterfly at this stage
  function automatic bit bfly_upper(input int idx, input int stage);
    return ((idx >> stage) & 1) == 0;
  endfunction

  // Width needed to count 0..n
  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/polar_fc_slicer.sv
module polar_fc_slicer #(
  parameter int LEN   = 16,
  parameter int LLR_W = 8
) (
  input  logic [LEN*LLR_W-1:0] llr_vec,
  output logic [LEN-1:0]       hard_vec
);
  // Negative LLR (sign bit set) maps to 1, zero and positive map to 0
  for (genvar i = 0; i < LEN; i++) begin : g_leaf
    assign hard_vec[i] = llr_vec[i*LLR_W + LLR_W - 1];
  end
endmodule

// File: rtl/polar_fc_xform.sv
module polar_fc_xform
  import polar_fc_pkg::*;
#(
  parameter int LEN = 16
) (
  input  logic [LEN-1:0] x_vec,
  output logic [LEN-1:0] u_vec
);
  localparam int STAGES = $clog2(LEN);

  logic [STAGES:0][LEN-1:0] lvl;
  assign lvl[0] = x_vec;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar i = 0; i < LEN; i++) begin : g_node
      if (bfly_upper(i, s)) begin : g_xor
        assign lvl[s+1][i] = lvl[s][i] ^ lvl[s][i + (1 << s)];
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign u_vec = lvl[STAGES];
endmodule

// File: rtl/polar_fc_scan.sv
module polar_fc_scan #(
  parameter int LEN   = 16,
  parameter int CNT_W = 5
) (
  input  logic [LEN-1:0]   leaf_vec,
  input  logic [LEN-1:0]   mask_vec,
  output logic [CNT_W-1:0] viol_cnt
);
  always_comb begin
    viol_cnt = '0;
    for (int i = 0; i < LEN; i++) begin
      viol_cnt = viol_cnt + CNT_W'(leaf_vec[i] & mask_vec[i]);
    end
  end
endmodule

// File: rtl/polar_fc_unit.sv
module polar_fc_unit
  import polar_fc_pkg::*;
#(
  parameter int LEN   = 16,
  parameter int LLR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LEN*LLR_W-1:0] llr_in,
  input  logic [LEN-1:0]       frz_mask,
  output logic [LEN-1:0]       est_out,
  output logic                 pass,
  output logic                 done
);
  localparam int CNT_W = count_width(LEN);

  // Named internal events, observed by the bound checker
  logic [LEN-1:0]   hard_vec;
  logic [LEN-1:0]   leaf_vec;
  logic [CNT_W-1:0] viol_cnt;
  logic             check_ok;

  polar_fc_slicer #(.LEN(LEN), .LLR_W(LLR_W)) slicer_i (
    .llr_vec (llr_in),
    .hard_vec(hard_vec)
  );

  polar_fc_xform #(.LEN(LEN)) xform_i (
    .x_vec(hard_vec),
    .u_vec(leaf_vec)
  );

  polar_fc_scan #(.LEN(LEN), .CNT_W(CNT_W)) scan_i (
    .leaf_vec(leaf_vec),
    .mask_vec(frz_mask),
    .viol_cnt(viol_cnt)
  );

  assign check_ok = (viol_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_out <= '0;
      pass    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        est_out <= hard_vec;
        pass    <= check_ok;
      end
    end
  end
endmodule

// File: rtl/polar_fc_unit_chk.sv
module polar_fc_unit_chk #(
  parameter int LEN   = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN-1:0]   frz_mask,
  input logic [LEN-1:0]   hard_vec,
  input logic [LEN-1:0]   leaf_vec,
  input logic [CNT_W-1:0] viol_cnt,
  input logic [LEN-1:0]   est_out,
  input logic             pass,
  input logic             done
);
  a_r6_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(est_out) && $stable(pass)));

  a_r5_pass_from_scan: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pass == ($past(viol_cnt) == '0)));

  a_r3_leaf_first_parity: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_vec[0] == ^hard_vec);

  a_r3_leaf_last_copy: assert property (@(posedge clk) disable iff (!rst_n)
    leaf_vec[LEN-1] == hard_vec[LEN-1]);

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(viol_cnt) <= $countones(frz_mask));
endmodule

bind polar_fc_unit polar_fc_unit_chk #(.LEN(LEN), .CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .frz_mask(frz_mask),
  .hard_vec(hard_vec),
  .leaf_vec(leaf_vec),
  .viol_cnt(viol_cnt),
  .est_out (est_out),
  .pass    (pass),
  .done    (done)
);

// File: tb/polar_fc_unit_tb_top.sv
module polar_fc_unit_tb_top;
  localparam int LEN = 16;
  localparam int W   = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [LEN*W-1:0] llr_in = '0;
  logic [LEN-1:0] frz_mask = '0;
  logic [LEN-1:0] est_out;
  logic           pass;
  logic           done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [LEN-1:0] m_est  = '0;
  logic           m_pass = 1'b0;
  logic           m_done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  polar_fc_unit #(.LEN(LEN), .LLR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .llr_in(llr_in),
    .frz_mask(frz_mask), .est_out(est_out), .pass(pass), .done(done)
  );

  // Reference: hard bits by integer sign, transform as subset sums
  task automatic ref_eval(input logic [LEN*W-1:0] l, input logic [LEN-1:0] m,
                          output logic [LEN-1:0] h, output logic p);
    int v;
    int bad;
    bad = 0;
    for (int i = 0; i < LEN; i++) begin
      v = int'($signed(l[i*W +: W]));
      h[i] = (v < 0);
    end
    for (int j = 0; j < LEN; j++) begin
      int acc;
      acc = 0;
      for (int i = 0; i < LEN; i++)
        if ((i & j) == j) acc = acc + int'(h[i]);
      if (m[j] && (acc % 2 == 1)) bad = bad + 1;
    end
    p = (bad == 0);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_est = '0; m_pass = 1'b0; m_done = 1'b0;
    end else begin
      m_done = start;
      if (start) ref_eval(llr_in, frz_mask, m_est, m_pass);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [LEN-1:0] act,
                     input logic [LEN-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk(est_out == '0 && !pass && !done, "R1 reset state",
            {est_out[LEN-1:2], pass, done}, '0);
      end else begin
        chk(done == m_done, "R6 done", LEN'(done), LEN'(m_done));
        chk(pass == m_pass, "R5 pass", LEN'(pass), LEN'(m_pass));
        chk(est_out == m_est, "R2 est_out", est_out, m_est);
      end
    end
  end

  function automatic logic [LEN*W-1:0] fill(input int v);
    logic [LEN*W-1:0] r;
    for (int i = 0; i < LEN; i++) r[i*W +: W] = W'(v);
    return r;
  endfunction

  // One check: present data with start, then look after the capture edge
  task automatic run_one(input logic [LEN*W-1:0] l, input logic [LEN-1:0] m,
                         input logic exp_p, input logic [LEN-1:0] exp_e,
                         input string tag);
    @(posedge clk); #2;
    llr_in = l; frz_mask = m; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, {tag, " done"}, LEN'(done), LEN'(1));
    chk(pass == exp_p, {tag, " pass"}, LEN'(pass), LEN'(exp_p));
    chk(est_out == exp_e, {tag, " est"}, est_out, exp_e);
  endtask

  initial begin
    logic [LEN*W-1:0] l;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(est_out == '0 && !pass && !done, "R1 after release", est_out, '0);

    // R2/R5: all non-negative gives zero transform, passes any mask
    run_one(fill(5), '1, 1'b1, '0, "R2 all positive");
    run_one(fill(0), '1, 1'b1, '0, "R2 zero LLR is 0");
    // R3: all negative leaves only leaf 15 set
    run_one(fill(-128), 16'h7FFF, 1'b1, '1, "R3 all negative leaf15 unmasked");
    run_one(fill(-1), 16'h8000, 1'b0, '1, "R3 all negative leaf15 frozen");
    // R4: single negative at leaf 0 sets only leaf 0
    l = fill(7); l[0 +: W] = W'(-3);
    run_one(l, 16'hFFFE, 1'b1, 16'h0001, "R4 leaf0 not frozen");
    run_one(l, 16'h0001, 1'b0, 16'h0001, "R4 leaf0 frozen");
    // R3: negatives at leaves 1 and 3 -> leaf estimates at 1,2,3? u1=h1^h3=0,u3=1,u2=h3=1,u0=0
    l = fill(9); l[1*W +: W] = W'(-2); l[3*W +: W] = W'(-2);
    run_one(l, 16'h0003, 1'b1, 16'h000A, "R3 leaves1and3 frozen01");
    run_one(l, 16'h0004, 1'b0, 16'h000A, "R3 leaves1and3 frozen2");

    // R7: inputs change without start; results hold
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2;
      llr_in = fill(-50 + k); frz_mask = 16'hFFFF;
      @(negedge clk);
      chk(est_out == 16'h000A && !pass, "R7 hold", est_out, 16'h000A);
    end

    // R8: back-to-back starts, pass then fail
    @(posedge clk); #2;
    llr_in = fill(3); frz_mask = '1; start = 1'b1;
    @(posedge clk); #2;
    llr_in = fill(-3); frz_mask = '1;
    @(negedge clk);
    chk(pass == 1'b1 && done, "R8 first pass", LEN'(pass), LEN'(1));
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk);
    chk(pass == 1'b0 && done, "R8 second clears pass", LEN'(pass), LEN'(0));

    // Random vectors, checked by the per-cycle model (R2 R3 R4 R5 R6)
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #2;
      for (int i = 0; i < LEN; i++)
        llr_in[i*W +: W] = W'($urandom_range(0, 255));
      frz_mask = LEN'($urandom) & LEN'($urandom);
      start = ($urandom_range(0, 3) != 0);
    end
    @(posedge clk); #2 start = 1'b0;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule